// File: doc/BRIEF.md
# Register-Controlled Running Light

This block animates a pattern across a row of LEDs. Software places a starting pattern, an animation mode and a pause count in three word registers. The pattern register then moves by itself on a programmable step timer and drives the LED outputs directly. Reading the pattern register returns the pattern as it is at that moment, not the value that was last written. A program can therefore watch the animation, or change its speed while it runs, without stopping it.

The register port is a single-cycle request/response interface. A request is taken on the clock edge where `req_i` is high. The response flag and the read data are registered and appear after that edge. Four animation modes are available: rotate left, rotate right, a bounce mode that moves a lit dot from one end to the other and back, and hold, which freezes the pattern.

Top module: `rlight_top`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, `led_o` is 0, `rvalid_o` is 0 and `rdata_o` is 0. The mode and delay registers read back as 0.
- R2: A write to word offset 0x0 loads `wdata_i[7:0]` into the pattern. `led_o` shows this value from the clock edge of the write onward.
- R3: Mode value 0 rotates the pattern left by one position per step: bit 7 moves to bit 0.
- R4: Mode value 1 rotates the pattern right by one position per step: bit 0 moves to bit 7.
- R5: Mode value 2 is bounce mode. While the direction is left, the pattern shifts left by one. When bit 7 is set, it instead shifts right and the direction becomes right. While the direction is right, the pattern shifts right. When bit 0 is set, it instead shifts left and the direction becomes left.
- R6: Mode value 3 holds the pattern unchanged.
- R7: With a delay value N at word offset 0x8, the pattern steps once every N+1 clock cycles. The first step comes N+1 edges after a pattern write. N = 0 steps on every clock.
- R8: A write to the delay register while the pattern is running takes effect from the next edge and does not stop the animation. If the running count already equals or exceeds the new value, the step happens on the next edge.
- R9: A pattern write restarts the pause count and sets the bounce direction to left.
- R10: Every request raises `rvalid_o` for the cycle after its edge, and `rvalid_o` is low otherwise. A read of offset 0x0 returns, after that edge, the live pattern as it was at the edge.
- R11: The mode register (word offset 0x4, 2 bits) and the delay register (word offset 0x8, 8 bits) read back their values, zero-extended. Reads of any other offset return 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| req_i | input | 1 | Register request, taken on the rising edge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address; bits [3:2] select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Response flag for the request of the previous cycle |
| led_o | output | 8 | Live pattern driven to the LEDs |

## Verification
The bench builds the block with its defaults: an 8-bit pattern, an 8-bit delay, a 4-bit address and 32-bit data. An 8-bit delay keeps even the largest pause used (0x42, 67 cycles per step) short enough to watch several full steps. With an 8-bit pattern, a full bounce round trip takes 14 steps, so two round trips fit in a short run. A cycle-level model in the bench tracks the pattern, the direction, the pause count and the registers. The bench compares the LEDs against it on every cycle. This brings within reach the restart on a pattern write, the immediate step when the delay is lowered below the running count, and reads of the pattern taken while it moves.

// File: rtl/rlight_pkg.sv
package rlight_pkg;
  typedef enum logic [1:0] {
    MODE_LEFT   = 2'd0,
    MODE_RIGHT  = 2'd1,
    MODE_BOUNCE = 2'd2,
    MODE_HOLD   = 2'd3
  } mode_e;

  localparam int unsigned IDX_PAT  = 0;
  localparam int unsigned IDX_MODE = 1;
  localparam int unsigned IDX_DLY  = 2;
endpackage

// File: rtl/rlight_timer.sv
module rlight_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             tick_o
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // A count at or above the limit steps, so lowering the delay never strands the counter.
  assign tick_o = (cnt_q >= dly_i);
  assign cnt_en = 1'b1;

  always_comb begin
    if (restart_i || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + DLY_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_count_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !tick_o) |=> (cnt_q == $past(cnt_q) + DLY_W'(1)));
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rlight_anim.sv
module rlight_anim
  import rlight_pkg::*;
#(
  parameter int unsigned PAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PAT_W-1:0] load_val_i,
  input  mode_e            mode_i,
  input  logic             step_i,
  output logic [PAT_W-1:0] pat_o
);
  logic [PAT_W-1:0] pat_q, pat_d;
  logic             dir_q, dir_d;   // 0 = moving left, 1 = moving right
  logic             pat_en;

  assign pat_en = load_i || step_i;

  always_comb begin
    pat_d = pat_q;
    dir_d = dir_q;
    if (load_i) begin
      pat_d = load_val_i;
      dir_d = 1'b0;
    end else if (step_i) begin
      unique case (mode_i)
        MODE_LEFT:  pat_d = {pat_q[PAT_W-2:0], pat_q[PAT_W-1]};
        MODE_RIGHT: pat_d = {pat_q[0], pat_q[PAT_W-1:1]};
        MODE_BOUNCE: begin
          if (!dir_q) begin
            if (pat_q[PAT_W-1]) begin
              pat_d = pat_q >> 1;
              dir_d = 1'b1;
            end else begin
              pat_d = pat_q << 1;
            end
          end else begin
            if (pat_q[0]) begin
              pat_d = pat_q << 1;
              dir_d = 1'b0;
            end else begin
              pat_d = pat_q >> 1;
            end
          end
        end
        default: pat_d = pat_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q <= '0;
      dir_q <= 1'b0;
    end else if (pat_en) begin
      pat_q <= pat_d;
      dir_q <= dir_d;
    end
  end

  assign pat_o = pat_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pat_q == $past(load_val_i)));
  p_rotate_keeps_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && (mode_i == MODE_LEFT || mode_i == MODE_RIGHT))
      |=> ($countones(pat_q) == $countones($past(pat_q))));
  p_bounce_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && mode_i == MODE_BOUNCE && $countones(pat_q) == 1)
      |=> ($countones(pat_q) == 1));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD && !load_i) |=> $stable(pat_q));
endmodule

// File: rtl/rlight_regs.sv
module rlight_regs
  import rlight_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned PAT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PAT_W-1:0]  live_pat_i,
  output mode_e             mode_o,
  output logic [DLY_W-1:0]  dly_o,
  output logic              pat_load_o,
  output logic [PAT_W-1:0]  pat_val_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              sel_pat, sel_mode, sel_dly, unmapped;
  logic              wr, rd, mode_en, dly_en;
  mode_e             mode_q;
  logic [DLY_W-1:0]  dly_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;

  assign idx      = addr_i[ADDR_W-1:2];
  assign sel_pat  = (idx == IDX_W'(IDX_PAT));
  assign sel_mode = (idx == IDX_W'(IDX_MODE));
  assign sel_dly  = (idx == IDX_W'(IDX_DLY));
  assign unmapped = !(sel_pat || sel_mode || sel_dly);
  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign mode_en  = wr && sel_mode;
  assign dly_en   = wr && sel_dly;

  assign pat_load_o = wr && sel_pat;
  assign pat_val_o  = wdata_i[PAT_W-1:0];

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      if (sel_pat)  rdata_d = DATA_W'(live_pat_i);
      if (sel_mode) rdata_d = DATA_W'(mode_q);
      if (sel_dly)  rdata_d = DATA_W'(dly_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_LEFT;
    else if (mode_en) mode_q <= mode_e'(wdata_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dly_q <= '0;
    else if (dly_en) dly_q <= wdata_i[DLY_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= req_i;
    end
  end

  assign mode_o   = mode_q;
  assign dly_o    = dly_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_resp_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
  p_no_resp_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o);
  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && unmapped) |=> (rdata_o == '0));
  p_unmapped_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && unmapped) |=> ($stable(mode_q) && $stable(dly_q)));
endmodule

// File: rtl/rlight_top.sv
module rlight_top
  import rlight_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned PAT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [PAT_W-1:0]  led_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  mode_e            mode;
  logic [DLY_W-1:0] dly;
  logic             pat_load, tick;
  logic [PAT_W-1:0] pat_val, pat;

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  rlight_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W), .PAT_W(PAT_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .live_pat_i (pat),
    .mode_o     (mode),
    .dly_o      (dly),
    .pat_load_o (pat_load),
    .pat_val_o  (pat_val),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  rlight_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .restart_i (pat_load),
    .dly_i     (dly),
    .tick_o    (tick)
  );

  rlight_anim #(.PAT_W(PAT_W)) u_anim (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (pat_load),
    .load_val_i (pat_val),
    .mode_i     (mode),
    .step_i     (tick),
    .pat_o      (pat)
  );

  assign led_o = pat;
endmodule

// File: tb/rlight_top_tb_top.sv
module rlight_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  led;

  int total = 0, bad = 0;

  // Reference model state
  logic [7:0] m_pat = '0, m_dly = '0, m_cnt = '0;
  logic [1:0] m_mode = '0;
  logic       m_dir = 1'b0;

  always #5 clk = ~clk;

  rlight_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .led_o(led)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return {24'd0, m_pat};
      2'd1:    return {30'd0, m_mode};
      2'd2:    return {24'd0, m_dly};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_edge(input bit rq, input bit w, input logic [3:0] a, input logic [31:0] d);
    bit st;
    st = (m_cnt >= m_dly);
    if (rq && w && a[3:2] == 2'd0) begin
      m_pat = d[7:0]; m_cnt = '0; m_dir = 1'b0;
    end else begin
      if (st) begin
        case (m_mode)
          2'd0: m_pat = {m_pat[6:0], m_pat[7]};
          2'd1: m_pat = {m_pat[0], m_pat[7:1]};
          2'd2: begin
            if (!m_dir) begin
              if (m_pat[7]) begin m_pat = m_pat >> 1; m_dir = 1'b1; end
              else m_pat = m_pat << 1;
            end else begin
              if (m_pat[0]) begin m_pat = m_pat << 1; m_dir = 1'b0; end
              else m_pat = m_pat >> 1;
            end
          end
          default: ;
        endcase
      end
      m_cnt = st ? 8'd0 : m_cnt + 8'd1;
    end
    if (rq && w && a[3:2] == 2'd1) m_mode = d[1:0];
    if (rq && w && a[3:2] == 2'd2) m_dly = d[7:0];
  endtask

  // One clock cycle: drive at the falling edge, check at the next falling edge.
  task automatic cyc(input bit rq, input bit w, input logic [3:0] a, input logic [31:0] d,
                     input string tag);
    logic [31:0] exp_rd;
    req = rq; we = w; addr = a; wdata = d;
    exp_rd = m_read(a);
    @(posedge clk);
    m_edge(rq, w, a, d);
    @(negedge clk);
    chk({tag, " led"}, {24'd0, led}, {24'd0, m_pat});
    chk("R10 rvalid", {31'd0, rvalid}, {31'd0, rq});
    if (rq && !w) chk({tag, " rdata"}, rdata, exp_rd);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'd0, 32'd0, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 led in reset", {24'd0, led}, 32'd0);
    chk("R1 rvalid in reset", {31'd0, rvalid}, 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    idle(4, "R1");
    rd(4'h4, "R1 mode reset");
    rd(4'h8, "R1 delay reset");
    rd(4'h0, "R1 pattern reset");
  endtask

  task automatic t_left;
    wr(4'h4, 32'd0, "R3"); wr(4'h8, 32'd0, "R7");
    wr(4'h0, 32'h0000_0003, "R2");
    idle(12, "R3 rotate left every clock");
  endtask

  task automatic t_right;
    wr(4'h4, 32'd1, "R4"); wr(4'h8, 32'd1, "R7");
    wr(4'h0, 32'hFFFF_FFFE, "R2");
    idle(20, "R4 rotate right pause 1");
  endtask

  task automatic t_bounce;
    wr(4'h4, 32'd2, "R5"); wr(4'h8, 32'd0, "R7");
    wr(4'h0, 32'h0000_0080, "R2");
    idle(30, "R5 bounce two round trips");
    wr(4'h0, 32'h0000_0001, "R2");
    idle(16, "R5 bounce from right end");
  endtask

  task automatic t_hold;
    wr(4'h4, 32'd3, "R6"); wr(4'h0, 32'h0000_005A, "R2");
    idle(10, "R6 hold");
  endtask

  task automatic t_delay_change;
    wr(4'h4, 32'd0, "R3"); wr(4'h8, 32'd5, "R7");
    wr(4'h0, 32'h0000_0001, "R2");
    idle(14, "R7 pause 5");
    wr(4'h8, 32'h42, "R8 delay 0x42 while running");
    rd(4'h8, "R8 delay readback");
    idle(140, "R8 slow rate");
    wr(4'h8, 32'd5, "R8");
    idle(3, "R8");
    wr(4'h8, 32'd1, "R8 delay below count");
    idle(8, "R8 fast rate");
  endtask

  task automatic t_restart;
    wr(4'h4, 32'd2, "R9"); wr(4'h8, 32'd2, "R9");
    wr(4'h0, 32'h0000_0080, "R9");
    idle(8, "R9 moving right");
    wr(4'h0, 32'h0000_0010, "R9 reload");
    idle(25, "R9 direction left after reload");
  endtask

  task automatic t_read;
    wr(4'h4, 32'd0, "R10"); wr(4'h8, 32'd0, "R10");
    wr(4'h0, 32'h0000_0011, "R10");
    for (int i = 0; i < 6; i++) rd(4'h0, "R10 live pattern read");
    idle(1, "R10 flag drops");
    rd(4'h4, "R11 mode read");
    rd(4'hC, "R11 unmapped read");
    wr(4'hC, 32'hFFFF_FFFF, "R11 unmapped write");
    rd(4'h4, "R11 mode unchanged");
    rd(4'h8, "R11 delay unchanged");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_left();
    t_right();
    t_bounce();
    t_hold();
    t_delay_change();
    t_restart();
    t_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule